// File: doc/BRIEF.md
# Egress Notification Scheduler

This block sits on one output port of a shared-buffer packet switch. Transmit notifications travel past every port on a one-way ring. Each notification carries a destination port mask, a 2-bit service class, a packet handle and the index of the packet's last cell. The block re-drives every notification to the next ring stop one cycle later. It keeps a copy of each notification whose mask includes its own port. A mask may name several ports, as it does for multicast and broadcast traffic.

When the port's fetch engine is idle and nothing is waiting, an accepted notification starts a fetch at once. In every other case the notification goes into one of four first-in first-out queues, chosen by its class. A weighted round-robin arbiter serves the four queues, with one programmable weight per queue in packets per turn. A notification can arrive before its packet has been fully written into the shared buffer. For that reason each fetch first asks the buffer whether the packet is present. On a miss it waits a programmable gap and asks again. After a hit it reads the packet's cells one per cycle and then pulses a read-done strobe once for that packet.

Top module: `egress_notify_sched`

## Requirements
- R1: Every notification presented on the ring input appears unchanged on the ring output one cycle later, whether or not this port is addressed, and the ring output is invalid in cycles after which no notification came in.
- R2: A notification is accepted only when bit PORT_ID of its mask is set, and other mask bits may also be set. A notification without that bit causes no presence check, no read and no read-done.
- R3: An accepted notification that finds the fetch engine idle and all four queues empty raises the presence request, carrying its handle, in the very next cycle.
- R4: Otherwise the notification is written to queue number equal to its class field (0 to 3). Each queue is first-in first-out. A notification aimed at a full queue is dropped, and the overflow output is high for the one cycle after it arrives.
- R5: Each presence request that sees the present input low increments the retry counter by one. The next request follows after retry_gap_i+1 cycles without a request, so a stalled fetch retries once every retry_gap_i+2 cycles.
- R6: After a presence hit, the block asserts the read strobe for cells 0 up to the last-cell index, one per consecutive cycle, each with the packet handle.
- R7: The read-done output pulses for one cycle, with the handle, in the cycle after the final cell read, exactly once per accepted notification that was not dropped.
- R8: The queues are served by weighted round-robin. Queue k's weight sits at bits k*WGT_W upward of the weight input. The current queue is served until it has used its weight or has emptied. Service then moves to the next non-empty queue in ascending, wrapping order. Queue 0 is current after reset.
- R9: During and right after reset, the block issues no forward, request, read, read-done or overflow, and the retry counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ntf_valid_i | input | 1 | Ring notification valid |
| ntf_mask_i | input | NPORTS | Destination port mask |
| ntf_class_i | input | 2 | Service class, selects the queue |
| ntf_id_i | input | ID_W | Packet handle in the shared buffer |
| ntf_last_i | input | LEN_W | Index of the packet's last cell |
| fwd_valid_o | output | 1 | Forwarded notification valid |
| fwd_mask_o | output | NPORTS | Forwarded mask |
| fwd_class_o | output | 2 | Forwarded class |
| fwd_id_o | output | ID_W | Forwarded handle |
| fwd_last_o | output | LEN_W | Forwarded last-cell index |
| weight_i | input | 4*WGT_W | Per-queue weights in packets per turn |
| retry_gap_i | input | GAP_W | Idle cycles added between presence checks |
| pres_req_o | output | 1 | Presence query |
| pres_id_o | output | ID_W | Handle being queried |
| pres_ok_i | input | 1 | Packet fully in buffer (same-cycle answer) |
| rd_req_o | output | 1 | Cell read strobe |
| rd_id_o | output | ID_W | Handle being read |
| rd_cell_o | output | LEN_W | Cell index being read |
| rd_done_o | output | 1 | Packet read finished |
| rd_done_id_o | output | ID_W | Handle of the finished packet |
| overflow_o | output | 1 | A notification was dropped on a full queue |
| retry_cnt_o | output | CNT_W | Number of presence misses since reset |

## Verification
The main pattern holds one packet absent so that the engine stays stuck retrying. Eleven notifications spread over four classes with unequal weights are loaded, and then every packet is released. The order of read-done strobes separates the weighted round-robin from plain round-robin and from strict priority, and the cell counts show that each packet's length was kept. Other patterns cover the following: a notification without this port's bit, which separates the acceptance filter from forwarding; a held-absent packet with a fixed gap, which pins the retry period; and five notifications into a four-deep queue, which separates dropping from blocking or overwriting.

// File: rtl/eqs_pkg.sv
package eqs_pkg;
  localparam int NQ = 4;
  localparam int QW = 2;

  typedef enum logic [1:0] {
    F_IDLE  = 2'd0,
    F_CHECK = 2'd1,
    F_WAIT  = 2'd2,
    F_READ  = 2'd3
  } fetch_st_t;
endpackage

// File: rtl/eqs_fifo.sv
module eqs_fifo #(
  parameter int W     = 7,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop && !empty) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({push && !full, pop && !empty})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R4: occupancy never exceeds the depth
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));
  // R4: the scheduler never pops an empty queue
  a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/eqs_wrr.sv
module eqs_wrr
  import eqs_pkg::*;
#(
  parameter int WGT_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NQ-1:0]       nonempty,
  input  logic [NQ*WGT_W-1:0] weights,
  input  logic                take,
  output logic [QW-1:0]       gnt,
  output logic                gnt_valid
);
  logic [QW-1:0]    cur, nxt, cand;
  logic [WGT_W-1:0] used, w_cur, eff;
  logic             stay, found;

  always_comb begin
    w_cur = weights[cur*WGT_W +: WGT_W];
    eff   = (w_cur == '0) ? WGT_W'(1) : w_cur;
    stay  = nonempty[cur] && (used < eff);
    nxt   = cur;
    found = 1'b0;
    cand  = cur;
    for (int k = 1; k <= NQ; k++) begin
      cand = cur + QW'(k);
      if (!found && nonempty[cand]) begin
        nxt   = cand;
        found = 1'b1;
      end
    end
    gnt       = stay ? cur : nxt;
    gnt_valid = |nonempty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      used <= '0;
    end else if (take) begin
      if (stay) begin
        used <= used + 1'b1;
      end else begin
        cur  <= nxt;
        used <= WGT_W'(1);
      end
    end
  end

  // R8: a grant always names a queue that holds work
  a_r8_grant_nonempty: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> nonempty[gnt]);
  // R8: the arbiter is only advanced when work exists
  a_r8_take_valid: assert property (@(posedge clk) disable iff (rst)
    take |-> gnt_valid);
endmodule

// File: rtl/eqs_fetch.sv
module eqs_fetch
  import eqs_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int LEN_W = 3,
  parameter int GAP_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ID_W-1:0]  start_id,
  input  logic [LEN_W-1:0] start_last,
  output logic             busy,
  input  logic [GAP_W-1:0] gap,
  output logic             pres_req,
  output logic [ID_W-1:0]  pres_id,
  input  logic             pres_ok,
  output logic             rd_req,
  output logic [ID_W-1:0]  rd_id,
  output logic [LEN_W-1:0] rd_cell,
  output logic             done,
  output logic [ID_W-1:0]  done_id,
  output logic [CNT_W-1:0] retry_cnt
);
  fetch_st_t        st;
  logic [ID_W-1:0]  id_q;
  logic [LEN_W-1:0] last_q, cell_q;
  logic [GAP_W-1:0] wait_q;

  assign busy     = (st != F_IDLE);
  assign pres_req = (st == F_CHECK);
  assign pres_id  = id_q;
  assign rd_req   = (st == F_READ);
  assign rd_id    = id_q;
  assign rd_cell  = cell_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= F_IDLE;
      id_q      <= '0;
      last_q    <= '0;
      cell_q    <= '0;
      wait_q    <= '0;
      done      <= 1'b0;
      done_id   <= '0;
      retry_cnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        F_IDLE: if (start) begin
          st     <= F_CHECK;
          id_q   <= start_id;
          last_q <= start_last;
        end
        F_CHECK: if (pres_ok) begin
          st     <= F_READ;
          cell_q <= '0;
        end else begin
          st        <= F_WAIT;
          wait_q    <= gap;
          retry_cnt <= retry_cnt + 1'b1;
        end
        F_WAIT: if (wait_q == '0) st <= F_CHECK;
                else wait_q <= wait_q - 1'b1;
        F_READ: if (cell_q == last_q) begin
          st      <= F_IDLE;
          done    <= 1'b1;
          done_id <= id_q;
        end else begin
          cell_q <= cell_q + 1'b1;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  // R3: a fetch is launched only into an idle engine
  a_r3_start_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  // R5: the retry counter moves by at most one per cycle
  a_r5_retry_step: assert property (@(posedge clk) disable iff (rst)
    (retry_cnt == $past(retry_cnt)) || (retry_cnt == $past(retry_cnt) + 1'b1));
  // R6: reading begins only after a presence hit
  a_r6_read_after_hit: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |-> $past(pres_req && pres_ok));
  // R7: read-done follows the final cell read of the same handle
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(rd_req) && $past(rd_cell) == $past(last_q) && done_id == $past(rd_id)));
endmodule

// File: rtl/egress_notify_sched.sv
module egress_notify_sched
  import eqs_pkg::*;
#(
  parameter int NPORTS  = 8,
  parameter int PORT_ID = 2,
  parameter int ID_W    = 4,
  parameter int LEN_W   = 3,
  parameter int WGT_W   = 3,
  parameter int GAP_W   = 4,
  parameter int CNT_W   = 16,
  parameter int QDEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ntf_valid_i,
  input  logic [NPORTS-1:0]   ntf_mask_i,
  input  logic [1:0]          ntf_class_i,
  input  logic [ID_W-1:0]     ntf_id_i,
  input  logic [LEN_W-1:0]    ntf_last_i,
  output logic                fwd_valid_o,
  output logic [NPORTS-1:0]   fwd_mask_o,
  output logic [1:0]          fwd_class_o,
  output logic [ID_W-1:0]     fwd_id_o,
  output logic [LEN_W-1:0]    fwd_last_o,
  input  logic [NQ*WGT_W-1:0] weight_i,
  input  logic [GAP_W-1:0]    retry_gap_i,
  output logic                pres_req_o,
  output logic [ID_W-1:0]     pres_id_o,
  input  logic                pres_ok_i,
  output logic                rd_req_o,
  output logic [ID_W-1:0]     rd_id_o,
  output logic [LEN_W-1:0]    rd_cell_o,
  output logic                rd_done_o,
  output logic [ID_W-1:0]     rd_done_id_o,
  output logic                overflow_o,
  output logic [CNT_W-1:0]    retry_cnt_o
);
  localparam int EW = ID_W + LEN_W;

  logic            hit, busy, bypass, take, any_q, gnt_valid, start;
  logic [QW-1:0]   gnt;
  logic [NQ-1:0]   q_push, q_pop, q_empty, q_full, q_ne;
  logic [EW-1:0]   q_dout [NQ];
  logic [EW-1:0]   in_entry, start_entry;

  // ring stop: one register stage, contents untouched
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid_o <= 1'b0;
      fwd_mask_o  <= '0;
      fwd_class_o <= '0;
      fwd_id_o    <= '0;
      fwd_last_o  <= '0;
    end else begin
      fwd_valid_o <= ntf_valid_i;
      fwd_mask_o  <= ntf_mask_i;
      fwd_class_o <= ntf_class_i;
      fwd_id_o    <= ntf_id_i;
      fwd_last_o  <= ntf_last_i;
    end
  end

  assign hit         = ntf_valid_i && ntf_mask_i[PORT_ID];
  assign in_entry    = {ntf_id_i, ntf_last_i};
  assign q_ne        = ~q_empty;
  assign any_q       = |q_ne;
  assign bypass      = hit && !busy && !any_q;
  assign take        = !busy && gnt_valid;
  assign start       = bypass || take;
  assign start_entry = bypass ? in_entry : q_dout[gnt];

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign q_push[q] = hit && !bypass && (ntf_class_i == QW'(q));
    assign q_pop[q]  = take && (gnt == QW'(q));
    eqs_fifo #(.W(EW), .DEPTH(QDEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (q_push[q]),
      .din   (in_entry),
      .pop   (q_pop[q]),
      .dout  (q_dout[q]),
      .empty (q_empty[q]),
      .full  (q_full[q])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) overflow_o <= 1'b0;
    else     overflow_o <= |(q_push & q_full);
  end

  eqs_wrr #(.WGT_W(WGT_W)) u_wrr (
    .clk       (clk),
    .rst       (rst),
    .nonempty  (q_ne),
    .weights   (weight_i),
    .take      (take),
    .gnt       (gnt),
    .gnt_valid (gnt_valid)
  );

  eqs_fetch #(.ID_W(ID_W), .LEN_W(LEN_W), .GAP_W(GAP_W), .CNT_W(CNT_W)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_id   (start_entry[EW-1:LEN_W]),
    .start_last (start_entry[LEN_W-1:0]),
    .busy       (busy),
    .gap        (retry_gap_i),
    .pres_req   (pres_req_o),
    .pres_id    (pres_id_o),
    .pres_ok    (pres_ok_i),
    .rd_req     (rd_req_o),
    .rd_id      (rd_id_o),
    .rd_cell    (rd_cell_o),
    .done       (rd_done_o),
    .done_id    (rd_done_id_o),
    .retry_cnt  (retry_cnt_o)
  );

  // R1: each ring notification is re-driven unchanged one cycle later
  a_r1_fwd_copy: assert property (@(posedge clk) disable iff (rst)
    ntf_valid_i |=> (fwd_valid_o && fwd_id_o == $past(ntf_id_i)
                     && fwd_mask_o == $past(ntf_mask_i)));
  // R3: idle engine with empty queues queries presence next cycle
  a_r3_bypass_query: assert property (@(posedge clk) disable iff (rst)
    (hit && !pres_req_o && !rd_req_o && !busy && !any_q) |=> (pres_req_o && pres_id_o == $past(ntf_id_i)));
  // R4: a notification meeting a full queue raises overflow
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (hit && !bypass && q_full[ntf_class_i]) |=> overflow_o);
endmodule

// File: tb/tb_egress_notify_sched.sv
module tb_egress_notify_sched;
  localparam int PERIOD = 10;
  localparam int NP = 8, PID = 2, IDW = 4, LW = 3, WW = 3, GW = 4, CW = 16;
  localparam logic [NP-1:0] MINE  = 8'b0000_0100;
  localparam logic [NP-1:0] MULTI = 8'b1000_0101;
  localparam logic [NP-1:0] OTHER = 8'b0011_0001;
  localparam int NV = 11;
  // {class[1:0], id[3:0], last[2:0], expected completion id[3:0]}
  localparam logic [12:0] VEC [NV] = '{
    {2'd0, 4'd0,  3'd2, 4'd0},  {2'd0, 4'd1,  3'd0, 4'd1},
    {2'd0, 4'd2,  3'd1, 4'd2},  {2'd0, 4'd3,  3'd3, 4'd4},
    {2'd1, 4'd4,  3'd0, 4'd6},  {2'd1, 4'd5,  3'd2, 4'd7},
    {2'd2, 4'd6,  3'd1, 4'd8},  {2'd2, 4'd7,  3'd0, 4'd10},
    {2'd2, 4'd8,  3'd4, 4'd3},  {2'd2, 4'd9,  3'd1, 4'd5},
    {2'd3, 4'd10, 3'd2, 4'd9}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ntf_valid = 1'b0;
  logic [NP-1:0] ntf_mask = '0;
  logic [1:0] ntf_class = '0;
  logic [IDW-1:0] ntf_id = '0;
  logic [LW-1:0] ntf_last = '0;
  logic fwd_valid; logic [NP-1:0] fwd_mask; logic [1:0] fwd_class;
  logic [IDW-1:0] fwd_id; logic [LW-1:0] fwd_last;
  logic [4*WW-1:0] weight = {3'd1, 3'd3, 3'd1, 3'd2};
  logic [GW-1:0] gap = 4'd1;
  logic pres_req, pres_ok, rd_req, rd_done, overflow;
  logic [IDW-1:0] pres_id, rd_id, rd_done_id;
  logic [LW-1:0] rd_cell;
  logic [CW-1:0] retry_cnt;
  logic [15:0] present = '0;

  assign pres_ok = present[pres_id];
  always #(PERIOD/2) clk = ~clk;

  egress_notify_sched dut (
    .clk(clk), .rst(rst),
    .ntf_valid_i(ntf_valid), .ntf_mask_i(ntf_mask), .ntf_class_i(ntf_class),
    .ntf_id_i(ntf_id), .ntf_last_i(ntf_last),
    .fwd_valid_o(fwd_valid), .fwd_mask_o(fwd_mask), .fwd_class_o(fwd_class),
    .fwd_id_o(fwd_id), .fwd_last_o(fwd_last),
    .weight_i(weight), .retry_gap_i(gap),
    .pres_req_o(pres_req), .pres_id_o(pres_id), .pres_ok_i(pres_ok),
    .rd_req_o(rd_req), .rd_id_o(rd_id), .rd_cell_o(rd_cell),
    .rd_done_o(rd_done), .rd_done_id_o(rd_done_id),
    .overflow_o(overflow), .retry_cnt_o(retry_cnt)
  );

  int checks = 0, errors = 0, mon_checks = 0, mon_errors = 0;
  int done_n = 0;
  int done_ids [64];
  int done_per [16];
  int cell_cnt [16];
  logic clr = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [NP-1:0] m, input logic [1:0] c,
                      input logic [IDW-1:0] i, input logic [LW-1:0] l);
    @(negedge clk);
    ntf_valid = 1'b1; ntf_mask = m; ntf_class = c; ntf_id = i; ntf_last = l;
    @(negedge clk);
    ntf_valid = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // monitor: samples 1 time unit after each rising edge
  always begin
    logic sv; logic [NP-1:0] sm; logic [1:0] sc; logic [IDW-1:0] si; logic [LW-1:0] sl;
    @(posedge clk);
    sv = ntf_valid; sm = ntf_mask; sc = ntf_class; si = ntf_id; sl = ntf_last;
    #1;
    if (clr) begin
      done_n = 0;
      for (int k = 0; k < 16; k++) begin done_per[k] = 0; cell_cnt[k] = 0; end
    end else if (!rst) begin
      mon_checks++;
      if (sv !== fwd_valid || (sv && (fwd_mask !== sm || fwd_class !== sc ||
                                      fwd_id !== si || fwd_last !== sl))) begin
        mon_errors++;
        $display("FAIL R1 forward actual=%0d/%0d expected=%0d/%0d", fwd_valid, fwd_id, sv, si);
      end
      if (rd_req) begin
        mon_checks++;
        if (int'(rd_cell) != cell_cnt[rd_id]) begin
          mon_errors++;
          $display("FAIL R6 cell order actual=%0d expected=%0d", rd_cell, cell_cnt[rd_id]);
        end
        cell_cnt[rd_id]++;
      end
      if (rd_done) begin
        if (done_n < 64) done_ids[done_n] = int'(rd_done_id);
        done_n++;
        done_per[rd_done_id]++;
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errors + 1);
    $finish;
  end

  initial begin
    int r0, r1;
    repeat (5) @(negedge clk);
    // R9: reset state
    chk(!fwd_valid && !pres_req && !rd_req && !rd_done && !overflow, "R9 outputs idle", 1, 0);
    chk(retry_cnt == '0, "R9 retry count", int'(retry_cnt), 0);
    rst = 1'b0;
    clear_log();

    // vector walk: id 0 bypasses and is held absent, the rest queue up
    for (int i = 0; i < NV; i++) begin
      send((i % 3 == 1) ? MULTI : MINE, VEC[i][12:11], VEC[i][10:7], VEC[i][6:4]);
      if (i == 0) begin
        chk(pres_req && pres_id == 4'd0, "R3 bypass query next cycle", int'(pres_req), 1);
        chk(retry_cnt == '0, "R5 no miss before first check", int'(retry_cnt), 0);
      end
    end
    repeat (4) @(negedge clk);
    chk(done_n == 0, "R5 absent packet not read", done_n, 0);
    chk(retry_cnt > 0, "R5 misses counted", int'(retry_cnt), 1);
    present = 16'hFFFF;
    repeat (80) @(negedge clk);
    chk(done_n == NV, "R7 all packets done", done_n, NV);
    for (int i = 0; i < NV; i++) begin
      chk(done_ids[i] == int'(VEC[i][3:0]), "R8 service order", done_ids[i], int'(VEC[i][3:0]));
      chk(done_per[VEC[i][10:7]] == 1, "R7 single done", done_per[VEC[i][10:7]], 1);
      chk(cell_cnt[VEC[i][10:7]] == int'(VEC[i][6:4]) + 1, "R6 cell count",
          cell_cnt[VEC[i][10:7]], int'(VEC[i][6:4]) + 1);
    end

    // R2: notification without this port's bit is not taken
    clear_log();
    r0 = int'(retry_cnt);
    send(OTHER, 2'd1, 4'd12, 3'd1);
    chk(!pres_req, "R2 no query for foreign mask", int'(pres_req), 0);
    repeat (20) @(negedge clk);
    chk(done_n == 0 && cell_cnt[12] == 0, "R2 foreign mask ignored", done_n, 0);
    chk(int'(retry_cnt) == r0, "R2 retry count untouched", int'(retry_cnt), r0);

    // R5: retry period is gap+2 cycles
    gap = 4'd3;
    present[13] = 1'b0;
    send(MINE, 2'd0, 4'd13, 3'd0);
    repeat (10) @(negedge clk);
    r0 = int'(retry_cnt);
    repeat (50) @(negedge clk);
    r1 = int'(retry_cnt);
    chk(r1 - r0 == 10, "R5 retry rate", r1 - r0, 10);
    present[13] = 1'b1;
    repeat (12) @(negedge clk);
    chk(done_n == 1 && done_per[13] == 1, "R7 done after retries", done_n, 1);

    // R4: five notifications into a four-deep queue
    clear_log();
    gap = 4'd1;
    present[14] = 1'b0;
    send(MINE, 2'd2, 4'd14, 3'd0);
    for (int k = 1; k <= 4; k++) begin
      send(MINE, 2'd2, IDW'(k), 3'd0);
      chk(!overflow, "R4 no overflow below depth", int'(overflow), 0);
    end
    send(MINE, 2'd2, 4'd5, 3'd0);
    chk(overflow, "R4 overflow on full queue", int'(overflow), 1);
    @(negedge clk);
    chk(!overflow, "R4 overflow one cycle", int'(overflow), 0);
    present[14] = 1'b1;
    repeat (40) @(negedge clk);
    chk(done_n == 5, "R4 dropped entry not read", done_n, 5);
    chk(done_per[5] == 0, "R4 dropped id absent", done_per[5], 0);
    for (int k = 1; k <= 4; k++)
      chk(done_ids[k] == k, "R4 queue FIFO order", done_ids[k], k);

    $display("  CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
    $finish;
  end
endmodule